// File: doc/BRIEF.md
# Multi-operand carry-save adder tree

This block adds a fixed set of N operands, N from 3 to 16, into a single W-bit result in one combinational path. Every operand has its own elaboration-time settings: how many of its bus bits are meaningful, whether it is a two's-complement value, and whether it is added or subtracted. Operands arrive on one flat bus, one W-bit slot per operand. The slot bits above an operand's declared width are don't-care.

Each operand is first widened to W bits. Subtracted operands are bit-inverted, and a single constant equal to the number of subtracted operands is appended as one extra summand, which makes the two's-complement arithmetic come out right. The summands then pass through levels of 3:2 compressors. At each level the ready vectors are grouped three at a time, and each group yields a sum vector and a carry vector shifted left by one bit. Vectors that are left over pass straight through to the next level. Once two vectors remain, one ordinary adder forms the result. All arithmetic is modulo 2^W.

Top module: `csa_tree_adder`

## Requirements
- R1: An unsigned operand narrower than W is zero-extended. With the default settings, operand 1 (8 bits, unsigned, added) set to 0xFF and all others zero gives 0x00FF.
- R2: A signed operand narrower than W is sign-extended from its top declared bit. With the defaults, operand 0 (12 bits, signed, added) set to 0x800 alone gives 0xF800.
- R3: The result is the sum modulo 2^W, and the carry out of the top bit is lost. With the defaults, operand 1 = 1 and operand 2 (16 bits, unsigned, subtracted) = 1 gives 0x0000.
- R4: A subtracted operand contributes the negative of its extended value. With the defaults, operand 2 = 1 alone gives 0xFFFF, and operand 3 (4 bits, signed, subtracted) = 0x8 alone gives 0x0008.
- R5: When every operand is subtracted, the result is the negated sum. For an instance with four 8-bit operands, signed mask 0101 and all operands subtracted, inputs 1, 2, 3, 4 give 0xF6.
- R6: All-zero operand inputs give a zero result.
- R7: For any inputs, the result equals the extend, add-or-subtract and truncate model. The two vectors that leave the compressor levels sum to the same value modulo 2^W as the summands that enter them.
- R8: Bit 0 of the result equals the XOR of bit 0 of every operand.
- R9: The block is combinational. A new input value shows at the result without any clock edge.
- R10: Slot bits above an operand's declared width have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operands_i | input | N*W | Operand k occupies bits [k*W +: W]; only the low width-of-k bits are used |
| result_o | output | W | Sum of all operands, modulo 2^W |

## Verification
The block holds no state, so each result is due zero clock cycles after its stimulus. The bench changes the operand bus just after a rising edge of its free-running clock. It reads the result at the following falling edge, half a period later, when every path has long settled. The check for R9 does not wait for an edge at all. It reads the result one nanosecond after changing the inputs.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  // vectors left after one level of 3:2 grouping
  function automatic int next_count(input int c);
    return 2 * (c / 3) + (c % 3);
  endfunction

  // number of compressor levels needed to reach two vectors
  function automatic int level_count(input int s0);
    int c;
    int l;
    c = s0;
    l = 0;
    while (c > 2) begin
      c = next_count(c);
      l++;
    end
    return l;
  endfunction

  // vector count entering a given level
  function automatic int count_at(input int s0, input int lvl);
    int c;
    c = s0;
    for (int i = 0; i < lvl; i++) c = next_count(c);
    return c;
  endfunction

  function automatic int count_ones(input logic [31:0] m);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction

endpackage

// File: rtl/csa_compress3.sv
module csa_compress3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] maj;

  assign sum_o   = a_i ^ b_i ^ c_i;
  assign maj     = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // weight of a carry is one bit higher; top carry falls off
  assign carry_o = maj << 1;

endmodule

// File: rtl/csa_reduce_level.sv
module csa_reduce_level #(
  parameter int W      = 16,
  parameter int CNT_IN = 3,
  localparam int CNT_OUT = 2 * (CNT_IN / 3) + (CNT_IN % 3)
) (
  input  logic [CNT_IN*W-1:0]  vec_i,
  output logic [CNT_OUT*W-1:0] vec_o
);

  localparam int NGRP = CNT_IN / 3;
  localparam int NREM = CNT_IN % 3;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    csa_compress3 #(.W(W)) u_cmp (
      .a_i    (vec_i[(3*g)*W   +: W]),
      .b_i    (vec_i[(3*g+1)*W +: W]),
      .c_i    (vec_i[(3*g+2)*W +: W]),
      .sum_o  (vec_o[(2*g)*W   +: W]),
      .carry_o(vec_o[(2*g+1)*W +: W])
    );
  end

  for (genvar k = 0; k < NREM; k++) begin : g_pass
    assign vec_o[(2*NGRP+k)*W +: W] = vec_i[(3*NGRP+k)*W +: W];
  end

endmodule

// File: rtl/csa_operand_prep.sv
module csa_operand_prep #(
  parameter int           N           = 5,
  parameter int           W           = 16,
  parameter logic [N*8-1:0] OP_WIDTHS = {8'd10, 8'd4, 8'd16, 8'd8, 8'd12},
  parameter logic [N-1:0] SIGNED_MASK = 5'b01001,
  parameter logic [N-1:0] SUB_MASK    = 5'b01100
) (
  input  logic [N*W-1:0] operands_i,
  output logic [N*W-1:0] summands_o
);

  for (genvar i = 0; i < N; i++) begin : g_op
    localparam int OW  = int'(OP_WIDTHS[i*8 +: 8]);
    localparam bit SGN = SIGNED_MASK[i];
    localparam bit SUB = SUB_MASK[i];

    logic [W-1:0] ext;

    if (OW < W) begin : g_pad
      logic pad_bit;
      logic unused_hi;
      assign pad_bit   = SGN ? operands_i[i*W+OW-1] : 1'b0;
      assign ext       = {{(W-OW){pad_bit}}, operands_i[i*W +: OW]};
      assign unused_hi = ^operands_i[i*W+OW +: W-OW];
    end else begin : g_full
      assign ext = operands_i[i*W +: W];
    end

    if (SUB) begin : g_neg
      assign summands_o[i*W +: W] = ~ext;
    end else begin : g_pos
      assign summands_o[i*W +: W] = ext;
    end
  end

endmodule

// File: rtl/csa_tree_adder.sv
module csa_tree_adder
  import csa_tree_pkg::*;
#(
  parameter int             N           = 5,
  parameter int             W           = 16,
  parameter logic [N*8-1:0] OP_WIDTHS   = {8'd10, 8'd4, 8'd16, 8'd8, 8'd12},
  parameter logic [N-1:0]   SIGNED_MASK = 5'b01001,
  parameter logic [N-1:0]   SUB_MASK    = 5'b01100
) (
  input  logic [N*W-1:0] operands_i,
  output logic [W-1:0]   result_o
);

  localparam int NSUB = count_ones(32'(SUB_MASK));
  localparam int S    = N + ((NSUB > 0) ? 1 : 0);
  localparam int LVLS = level_count(S);

  logic [N*W-1:0] prepped;
  logic [S*W-1:0] summands_w;
  logic [2*W-1:0] pair_w;

  csa_operand_prep #(
    .N(N), .W(W), .OP_WIDTHS(OP_WIDTHS),
    .SIGNED_MASK(SIGNED_MASK), .SUB_MASK(SUB_MASK)
  ) u_prep (
    .operands_i(operands_i),
    .summands_o(prepped)
  );

  if (NSUB > 0) begin : g_corr
    assign summands_w = {W'(NSUB), prepped};
  end else begin : g_nocorr
    assign summands_w = prepped;
  end

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int CI = count_at(S, l);
    localparam int CO = count_at(S, l + 1);
    logic [CI*W-1:0] v_in;
    logic [CO*W-1:0] v_out;

    if (l == 0) begin : g_first
      assign v_in = summands_w;
    end else begin : g_next
      assign v_in = g_lvl[l-1].v_out;
    end

    csa_reduce_level #(.W(W), .CNT_IN(CI)) u_level (
      .vec_i(v_in),
      .vec_o(v_out)
    );
  end

  assign pair_w   = g_lvl[LVLS-1].v_out;
  assign result_o = pair_w[W-1:0] + pair_w[2*W-1:W];

endmodule

// File: rtl/csa_tree_adder_chk.sv
module csa_tree_adder_chk
  import csa_tree_pkg::*;
#(
  parameter int             N           = 5,
  parameter int             W           = 16,
  parameter logic [N*8-1:0] OP_WIDTHS   = {8'd10, 8'd4, 8'd16, 8'd8, 8'd12},
  parameter logic [N-1:0]   SIGNED_MASK = 5'b01001,
  parameter logic [N-1:0]   SUB_MASK    = 5'b01100,
  localparam int S = N + ((count_ones(32'(SUB_MASK)) > 0) ? 1 : 0)
) (
  input logic [N*W-1:0] operands_i,
  input logic [W-1:0]   result_o,
  input logic [S*W-1:0] tree_in,
  input logic [2*W-1:0] tree_pair
);

  logic [W-1:0] model_v;
  logic [W-1:0] in_sum;
  logic [W-1:0] ext_v;
  logic         lsb_par;
  int           ow;

  always_comb begin
    model_v = '0;
    lsb_par = 1'b0;
    for (int i = 0; i < N; i++) begin
      ow    = int'(OP_WIDTHS[i*8 +: 8]);
      ext_v = '0;
      for (int b = 0; b < W; b++) begin
        if (b < ow) ext_v[b] = operands_i[i*W+b];
        else        ext_v[b] = SIGNED_MASK[i] & operands_i[i*W+ow-1];
      end
      model_v = SUB_MASK[i] ? (model_v - ext_v) : (model_v + ext_v);
      lsb_par = lsb_par ^ operands_i[i*W];
    end
    in_sum = '0;
    for (int s = 0; s < S; s++) in_sum = in_sum + tree_in[s*W +: W];
  end

  always_comb begin
    // R7 and R4: output matches extend/add/subtract/truncate model
    assert_model_match_R7: assert (result_o == model_v)
      else $error("result %h differs from model %h", result_o, model_v);
    // R7: compressor levels keep the sum of the summands
    assert_tree_keeps_sum_R7: assert (W'(tree_pair[W-1:0] + tree_pair[2*W-1:W]) == in_sum)
      else $error("tree pair sum differs from summand sum");
    // R8: result LSB parity
    assert_lsb_parity_R8: assert (result_o[0] == lsb_par)
      else $error("result lsb %b, parity %b", result_o[0], lsb_par);
    // R6: zeros in, zero out
    if (operands_i == '0) begin
      assert_zero_in_zero_out_R6: assert (result_o == '0)
        else $error("zero inputs gave %h", result_o);
    end
  end

endmodule

bind csa_tree_adder csa_tree_adder_chk #(
  .N(N), .W(W), .OP_WIDTHS(OP_WIDTHS),
  .SIGNED_MASK(SIGNED_MASK), .SUB_MASK(SUB_MASK)
) u_chk (
  .operands_i(operands_i),
  .result_o  (result_o),
  .tree_in   (summands_w),
  .tree_pair (pair_w)
);

// File: tb/sim_csa_tree_adder.sv
module sim_csa_tree_adder;

  localparam int N0 = 5;
  localparam int W0 = 16;
  localparam logic [N0*8-1:0] WID0 = {8'd10, 8'd4, 8'd16, 8'd8, 8'd12};
  localparam logic [N0-1:0]   SG0  = 5'b01001;
  localparam logic [N0-1:0]   SB0  = 5'b01100;

  localparam int N1 = 4;
  localparam int W1 = 8;
  localparam logic [N1*8-1:0] WID1 = {8'd8, 8'd8, 8'd8, 8'd8};
  localparam logic [N1-1:0]   SG1  = 4'b0101;
  localparam logic [N1-1:0]   SB1  = 4'b1111;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [N0*W0-1:0] ops0;
  logic [W0-1:0]    res0;
  logic [N1*W1-1:0] ops1;
  logic [W1-1:0]    res1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  csa_tree_adder #(.N(N0), .W(W0), .OP_WIDTHS(WID0), .SIGNED_MASK(SG0), .SUB_MASK(SB0))
    u0 (.operands_i(ops0), .result_o(res0));

  csa_tree_adder #(.N(N1), .W(W1), .OP_WIDTHS(WID1), .SIGNED_MASK(SG1), .SUB_MASK(SB1))
    u1 (.operands_i(ops1), .result_o(res1));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference for the default instance
  function automatic logic [15:0] model0(input logic [N0*W0-1:0] v);
    logic [15:0] acc;
    logic [15:0] e;
    int ow;
    acc = '0;
    for (int i = 0; i < N0; i++) begin
      ow = int'(WID0[i*8 +: 8]);
      e  = v[i*W0 +: W0];
      for (int b = ow; b < W0; b++) e[b] = SG0[i] ? v[i*W0+ow-1] : 1'b0;
      acc = SB0[i] ? acc - e : acc + e;
    end
    return acc;
  endfunction

  function automatic logic [N0*W0-1:0] put0(input logic [N0*W0-1:0] v, input int k,
                                            input logic [15:0] x);
    logic [N0*W0-1:0] r;
    r = v;
    r[k*W0 +: W0] = x;
    return r;
  endfunction

  task automatic apply0(input logic [N0*W0-1:0] v);
    @(posedge clk);
    ops0 = v;
    @(negedge clk);
  endtask

  task automatic apply1(input logic [N1*W1-1:0] v);
    @(posedge clk);
    ops1 = v;
    @(negedge clk);
  endtask

  task automatic t_zero;
    apply0('0);
    check("R6 zero inputs", res0, 16'h0000);
    apply1('0);
    check("R6 zero inputs all-sub", {8'h00, res1}, 16'h0000);
  endtask

  task automatic t_unsigned_ext;
    apply0(put0('0, 1, 16'h00FF));
    check("R1 zero extension", res0, 16'h00FF);
  endtask

  task automatic t_signed_ext;
    apply0(put0('0, 0, 16'h0800));
    check("R2 sign extension most negative", res0, 16'hF800);
    apply0(put0('0, 0, 16'h07FF));
    check("R2 sign extension most positive", res0, 16'h07FF);
  endtask

  task automatic t_subtract;
    apply0(put0('0, 2, 16'h0001));
    check("R4 subtract one", res0, 16'hFFFF);
    apply0(put0('0, 3, 16'h0008));
    check("R4 subtract most negative signed", res0, 16'h0008);
  endtask

  task automatic t_wrap;
    apply0(put0(put0('0, 1, 16'h0001), 2, 16'h0001));
    check("R3 wrap to zero", res0, 16'h0000);
    apply0(put0('0, 2, 16'h8000));
    check("R3 negate most negative", res0, 16'h8000);
  endtask

  task automatic t_all_ones;
    // -1 + 255 - 65535 - (-1) + 1023 = 1279 mod 2^16
    apply0('1);
    check("R1 R2 all ones", res0, 16'h04FF);
  endtask

  task automatic t_all_sub;
    apply1({8'd4, 8'd3, 8'd2, 8'd1});
    check("R5 all subtracted small", {8'h00, res1}, 16'h00F6);
    apply1({4{8'hFF}});
    check("R5 all subtracted ones", {8'h00, res1}, 16'h0004);
    apply1({4{8'h80}});
    check("R5 all subtracted most negative", {8'h00, res1}, 16'h0000);
  endtask

  task automatic t_ignored_bits;
    apply0(put0(put0('0, 1, 16'hAB05), 3, 16'hFFF0));
    check("R10 upper slot bits ignored", res0, 16'h0005);
  endtask

  task automatic t_comb;
    @(posedge clk);
    ops0 = put0('0, 4, 16'h0123);
    #1;
    check("R9 result without clock edge", res0, 16'h0123);
    @(negedge clk);
  endtask

  task automatic t_random;
    logic [N0*W0-1:0] v;
    logic par;
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < N0; k++) v[k*W0 +: W0] = 16'($urandom);
      apply0(v);
      check("R7 random vector", res0, model0(v));
      par = 1'b0;
      for (int k = 0; k < N0; k++) par = par ^ v[k*W0];
      check("R8 lsb parity", {15'h0, res0[0]}, {15'h0, par});
    end
  endtask

  initial begin
    ops0 = '0;
    ops1 = '0;
    @(negedge clk);
    check("R6 initial state", res0, 16'h0000);
    t_zero();
    t_unsigned_ext();
    t_signed_ext();
    t_subtract();
    t_wrap();
    t_all_ones();
    t_all_sub();
    t_ignored_bits();
    t_comb();
    t_random();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule